// File: doc/BRIEF.md
# Bus Bandwidth Monitor Counter

This block watches the traffic of one or more bus ports and totals the bytes each port moves into a per-port counter. Each transfer is a single-cycle valid strobe that carries a byte count. Software can start and stop each counter, zero it, read it back and give it a limit. The counter then flags a limit hit or a counter carry in a sticky status field. A per-port interrupt enable sends that status to a shared global section. The global section holds one status bit and one enable bit per port, and it drives a single interrupt line.

A build-time parameter picks one of two counting styles. In limit-wrap mode the counter subtracts the limit each time the running total reaches it, so the count keeps only the excess, and it raises the hit flag. In free-run mode the counter passes through the limit, raises the hit flag when it crosses the limit, and raises a separate carry flag when it rolls over its full width. In either mode software gets the true byte total back from the count plus a correction taken from the status bits. In limit-wrap mode the correction is the limit. In free-run mode it is 2^CNT_W.

Software reaches the block over a simple register bus. `cfg_global` selects the global section. When it is low, `cfg_port` selects a port. Reads are combinational from the current address.

Top module: `bw_traffic_monitor`

## Requirements
- R1: After reset, for every port, the count, status, run and interrupt enable read as 0. The limit reads as all ones within CNT_W bits. Global status and global enable read 0, and `irq_out` is low.
- R2: Port register 0x280 bit 0 is the run control. While it is 1, each cycle with the port's valid bit high adds that port's byte field to the count at the next clock edge. While it is 0, the count holds its value and traffic is ignored.
- R3: Writing a value with bit 0 set to port register 0x284 zeroes the count at the next edge. If an increment falls in the same cycle, the clear wins and the increment is dropped.
- R4: In limit-wrap mode (WRAP_ON_LIMIT=1), when count plus bytes is at or above the limit, the count becomes count plus bytes minus the limit and status bit 0 (hit) sets. Status bit 1 never sets.
- R5: In free-run mode (WRAP_ON_LIMIT=0), the count advances modulo 2^CNT_W. Status bit 0 sets when a step takes the count from below the limit to a value at or above it, measured before truncation. Status bit 1 (carry) sets when the sum exceeds 2^CNT_W-1.
- R6: Status bits are sticky. Writing port register 0x108 clears each status bit whose data bit is 1 (bits [1:0]). A set that falls in the same cycle as a clear wins.
- R7: Port register 0x10C bit 0 is the local interrupt enable. Global status bit N sets one cycle after port N has nonzero status and its local enable is set. The global section holds status at 0x100 and enable at 0x10C, with bit N for port N. Writing global 0x108 clears the marked bits, and a set in the same cycle wins.
- R8: `irq_out` is high exactly when some port has both its global status bit and its global enable bit set.
- R9: The count reads at port 0x288 and the limit at 0x290. The limit is written through 0x290. Status, run and enable registers read back at their offsets. The clear registers (0x108, 0x284) and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_global | input | 1 | 1 selects the global section, 0 selects a port |
| cfg_port | input | PORT_IDX_W | Port index for port register access |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the current address, combinational |
| xfer_valid | input | NUM_PORTS | One transfer strobe per port |
| xfer_bytes | input | NUM_PORTS*BYTES_W | Byte count of each port's transfer, port N at bits [N*BYTES_W +: BYTES_W] |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two pairs of functions in this block can land in the same cycle. The first pair is a counter clear and a traffic increment. The second pair is a status set and a software write-one-to-clear. The bench drives full-rate traffic on every cycle and issues a counter clear in the middle of it. It then sets a limit smaller than one transfer, so that a hit fires on every cycle, and writes a status clear against that stream. A behavioural model steps on every clock and predicts a zero count in the first case and a hit bit that stays set in the second. The read data and the interrupt line are compared with the model on every cycle, for both build modes side by side.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_STAT_CLR = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_RUN      = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_CNT_CLR  = 12'h284;
  localparam logic [ADDR_W-1:0] OFS_COUNT    = 12'h288;
  localparam logic [ADDR_W-1:0] OFS_LIMIT    = 12'h290;

  localparam int ST_HIT = 0;
  localparam int ST_OVF = 1;

  typedef logic [1:0] mon_status_t;
endpackage

// File: rtl/bwm_port_counter.sv
module bwm_port_counter
  import bwm_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int BYTES_W       = 8,
  parameter bit WRAP_ON_LIMIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              xfer_valid,
  input  logic [BYTES_W-1:0] xfer_bytes,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  limit_o,
  output mon_status_t       status_o,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              pending_o
);
  localparam int SUM_W    = CNT_W + 1;
  localparam int BYTE_MAX = (1 << BYTES_W) - 1;

  logic [CNT_W-1:0] count_q, count_d, limit_q, limit_d;
  mon_status_t      status_q, status_d, step_set, stat_clr_mask;
  logic             run_q, run_d, irq_en_q, irq_en_d;
  logic             wr_run, wr_limit, wr_irq_en, wr_stat_clr, clr_req, step;
  logic             count_ce;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] step_cnt;

  assign wr_run      = wr_en && (wr_addr == OFS_RUN);
  assign wr_limit    = wr_en && (wr_addr == OFS_LIMIT);
  assign wr_irq_en   = wr_en && (wr_addr == OFS_IRQ_EN);
  assign wr_stat_clr = wr_en && (wr_addr == OFS_STAT_CLR);
  assign clr_req     = wr_en && (wr_addr == OFS_CNT_CLR) && wr_data[0];
  assign step        = run_q && xfer_valid && !clr_req;
  assign stat_clr_mask = wr_stat_clr ? wr_data[1:0] : 2'b00;

  assign sum = {1'b0, count_q} + SUM_W'(xfer_bytes);

  generate
    if (WRAP_ON_LIMIT) begin : g_wrap
      logic             reach;
      logic [SUM_W-1:0] rem;
      assign reach    = sum >= {1'b0, limit_q};
      assign rem      = sum - {1'b0, limit_q};
      assign step_cnt = reach ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
      assign step_set = {1'b0, reach};

      // R4: a count below a limit wider than one transfer stays below it
      p_wrap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_limit && (count_q < limit_q) && (limit_q > CNT_W'(BYTE_MAX)))
          |=> (count_q < limit_q));
    end else begin : g_free
      assign step_cnt = sum[CNT_W-1:0];
      assign step_set = {sum[CNT_W], (count_q < limit_q) && (sum >= {1'b0, limit_q})};

      // R5: a carry out of the counter raises the carry flag
      p_carry_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sum[CNT_W]) |=> status_q[ST_OVF]);
    end
  endgenerate

  always_comb begin
    count_d  = count_q;
    status_d = status_q & ~stat_clr_mask;
    if (clr_req) begin
      count_d = '0;
    end else if (step) begin
      count_d  = step_cnt;
      status_d = status_d | step_set;
    end
    run_d    = wr_run    ? wr_data[0] : run_q;
    irq_en_d = wr_irq_en ? wr_data[0] : irq_en_q;
    limit_d  = wr_limit  ? wr_data    : limit_q;
  end

  assign count_ce = clr_req | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      limit_q  <= '1;
      status_q <= '0;
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (count_ce)  count_q  <= count_d;
      if (wr_limit)  limit_q  <= limit_d;
      if (wr_run)    run_q    <= run_d;
      if (wr_irq_en) irq_en_q <= irq_en_d;
      status_q <= status_d;
    end
  end

  assign count_o   = count_q;
  assign limit_o   = limit_q;
  assign status_o  = status_q;
  assign run_o     = run_q;
  assign irq_en_o  = irq_en_q;
  assign pending_o = (status_q != 2'b00) && irq_en_q;

  // R3: a counter clear beats any same-cycle increment
  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count_q == '0));

  // R2: a stopped counter keeps its value
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_req) |=> $stable(count_q));

  // R6: without a clear write no status bit drops
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat_clr |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/bwm_irq_combine.sv
module bwm_irq_combine
  import bwm_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_PORTS-1:0] wr_bits,
  input  logic [NUM_PORTS-1:0] pending,
  output logic [NUM_PORTS-1:0] gstat_o,
  output logic [NUM_PORTS-1:0] gen_o,
  output logic                 irq_o
);
  logic [NUM_PORTS-1:0] gstat_q, gstat_d, gen_q, gen_d, clr_mask;
  logic                 wr_gen, wr_clr;

  assign wr_gen   = wr_en && (wr_addr == OFS_IRQ_EN);
  assign wr_clr   = wr_en && (wr_addr == OFS_STAT_CLR);
  assign clr_mask = wr_clr ? wr_bits : '0;

  always_comb begin
    gstat_d = (gstat_q & ~clr_mask) | pending;
    gen_d   = wr_gen ? wr_bits : gen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gstat_q <= '0;
      gen_q   <= '0;
    end else begin
      gstat_q <= gstat_d;
      if (wr_gen) gen_q <= gen_d;
    end
  end

  assign gstat_o = gstat_q;
  assign gen_o   = gen_q;
  assign irq_o   = |(gstat_q & gen_q);

  // R7: a pending port shows up in global status on the next cycle
  p_gstat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending) |=> ((gstat_q & $past(pending)) == $past(pending)));
endmodule

// File: rtl/bw_traffic_monitor.sv
module bw_traffic_monitor
  import bwm_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int CNT_W         = 32,
  parameter int BYTES_W       = 8,
  parameter bit WRAP_ON_LIMIT = 1'b1,
  localparam int PORT_IDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_global,
  input  logic [PORT_IDX_W-1:0]        cfg_port,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  input  logic [NUM_PORTS-1:0]         xfer_valid,
  input  logic [NUM_PORTS*BYTES_W-1:0] xfer_bytes,
  output logic                         irq_out
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [CNT_W-1:0]     cnt_arr   [NUM_PORTS];
  logic [CNT_W-1:0]     lim_arr   [NUM_PORTS];
  mon_status_t          sts_arr   [NUM_PORTS];
  logic [NUM_PORTS-1:0] run_vec, ien_vec, pend_vec, gstat, gen;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic port_we;
      assign port_we = cfg_we && !cfg_global && (cfg_port == PORT_IDX_W'(i));
      bwm_port_counter #(
        .CNT_W(CNT_W), .BYTES_W(BYTES_W), .WRAP_ON_LIMIT(WRAP_ON_LIMIT)
      ) u_cnt (
        .clk(clk), .rst_n(rst_n_int),
        .wr_en(port_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata[CNT_W-1:0]),
        .xfer_valid(xfer_valid[i]), .xfer_bytes(xfer_bytes[i*BYTES_W +: BYTES_W]),
        .count_o(cnt_arr[i]), .limit_o(lim_arr[i]), .status_o(sts_arr[i]),
        .run_o(run_vec[i]), .irq_en_o(ien_vec[i]), .pending_o(pend_vec[i])
      );
    end
  endgenerate

  bwm_irq_combine #(.NUM_PORTS(NUM_PORTS)) u_irq (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(cfg_we && cfg_global), .wr_addr(cfg_addr),
    .wr_bits(cfg_wdata[NUM_PORTS-1:0]), .pending(pend_vec),
    .gstat_o(gstat), .gen_o(gen), .irq_o(irq_out)
  );

  logic port_ok;
  assign port_ok = (int'(cfg_port) < NUM_PORTS);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_global) begin
      case (cfg_addr)
        OFS_STATUS: cfg_rdata = DATA_W'(gstat);
        OFS_IRQ_EN: cfg_rdata = DATA_W'(gen);
        default:    cfg_rdata = '0;
      endcase
    end else if (port_ok) begin
      case (cfg_addr)
        OFS_STATUS: cfg_rdata = DATA_W'(sts_arr[cfg_port]);
        OFS_IRQ_EN: cfg_rdata = DATA_W'(ien_vec[cfg_port]);
        OFS_RUN:    cfg_rdata = DATA_W'(run_vec[cfg_port]);
        OFS_COUNT:  cfg_rdata = DATA_W'(cnt_arr[cfg_port]);
        OFS_LIMIT:  cfg_rdata = DATA_W'(lim_arr[cfg_port]);
        default:    cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/bw_traffic_monitor_tb_top.sv
module bw_traffic_monitor_tb_top;
  localparam int NP = 2;
  localparam int BW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_global = 1'b0;
  logic [0:0]  cfg_port = 1'b0;
  logic [11:0] cfg_addr = 12'h288;
  logic [31:0] cfg_wdata = '0;
  logic [NP-1:0]    xfer_valid = '0;
  logic [NP*BW-1:0] xfer_bytes = '0;
  logic [31:0] rdata_w, rdata_o;
  logic        irq_w, irq_o;

  bw_traffic_monitor #(.NUM_PORTS(NP), .CNT_W(32), .BYTES_W(BW), .WRAP_ON_LIMIT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_global(cfg_global), .cfg_port(cfg_port),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_w),
    .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .irq_out(irq_w));

  bw_traffic_monitor #(.NUM_PORTS(NP), .CNT_W(16), .BYTES_W(BW), .WRAP_ON_LIMIT(1'b0)) dut_ovf_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_global(cfg_global), .cfg_port(cfg_port),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata[15:0] == cfg_wdata[15:0] ? cfg_wdata : cfg_wdata),
    .cfg_rdata(rdata_o), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .irq_out(irq_o));

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  int    traf_mode = 0;
  logic        idle_g = 1'b0;
  logic [0:0]  idle_p = 1'b0;
  logic [11:0] idle_a = 12'h288;

  // behavioural model, index [dut][port]; dut 0 wraps on limit, dut 1 runs free at 16 bits
  longint m_cnt [2][NP];
  longint m_thr [2][NP];
  longint tot   [2][NP];
  bit     m_run [2][NP];
  bit     m_ien [2][NP];
  bit [1:0] m_sts [2][NP];
  bit [NP-1:0] m_gsts [2];
  bit [NP-1:0] m_gen  [2];

  function automatic longint span(int d);
    return (d == 0) ? 64'h1_0000_0000 : 64'h1_0000;
  endfunction

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int p = 0; p < NP; p++) begin
          m_cnt[d][p] = 0; m_thr[d][p] = span(d) - 1; m_run[d][p] = 0;
          m_ien[d][p] = 0; m_sts[d][p] = 0; tot[d][p] = 0;
        end
        m_gsts[d] = '0; m_gen[d] = '0;
      end else begin
        bit [NP-1:0] pend;
        bit [NP-1:0] g;
        for (int p = 0; p < NP; p++) pend[p] = (m_sts[d][p] != 0) && m_ien[d][p];
        for (int p = 0; p < NP; p++) begin
          bit     sel;
          bit [1:0] ns;
          longint b, s;
          sel = cfg_we && !cfg_global && (int'(cfg_port) == p);
          b   = longint'(xfer_bytes[p*BW +: BW]);
          ns  = m_sts[d][p];
          if (sel && cfg_addr == 12'h108) ns = ns & ~cfg_wdata[1:0];
          if (sel && cfg_addr == 12'h284 && cfg_wdata[0]) begin
            m_cnt[d][p] = 0; tot[d][p] = 0;
          end else if (m_run[d][p] && xfer_valid[p]) begin
            s = m_cnt[d][p] + b;
            tot[d][p] += b;
            if (d == 0) begin
              if (s >= m_thr[d][p]) begin m_cnt[d][p] = s - m_thr[d][p]; ns[0] = 1'b1; end
              else m_cnt[d][p] = s;
            end else begin
              if (m_cnt[d][p] < m_thr[d][p] && s >= m_thr[d][p]) ns[0] = 1'b1;
              if (s >= span(d)) begin ns[1] = 1'b1; m_cnt[d][p] = s - span(d); end
              else m_cnt[d][p] = s;
            end
          end
          m_sts[d][p] = ns;
          if (sel && cfg_addr == 12'h280) m_run[d][p] = cfg_wdata[0];
          if (sel && cfg_addr == 12'h10C) m_ien[d][p] = cfg_wdata[0];
          if (sel && cfg_addr == 12'h290) m_thr[d][p] = longint'(cfg_wdata) & (span(d) - 1);
        end
        g = m_gsts[d];
        if (cfg_we && cfg_global && cfg_addr == 12'h108) g = g & ~cfg_wdata[NP-1:0];
        m_gsts[d] = g | pend;
        if (cfg_we && cfg_global && cfg_addr == 12'h10C) m_gen[d] = cfg_wdata[NP-1:0];
      end
    end
  end

  function automatic logic [31:0] exp_read(int d);
    int p;
    p = int'(cfg_port);
    if (cfg_global) begin
      if (cfg_addr == 12'h100) return 32'(m_gsts[d]);
      if (cfg_addr == 12'h10C) return 32'(m_gen[d]);
      return 32'h0;
    end
    case (cfg_addr)
      12'h100: return 32'(m_sts[d][p]);
      12'h10C: return 32'(m_ien[d][p]);
      12'h280: return 32'(m_run[d][p]);
      12'h288: return 32'(m_cnt[d][p]);
      12'h290: return 32'(m_thr[d][p]);
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int d = 0; d < 2; d++) begin
        logic [31:0] got, exp;
        logic gi, ei;
        got = (d == 0) ? rdata_w : rdata_o;
        exp = exp_read(d);
        gi  = (d == 0) ? irq_w : irq_o;
        ei  = |(m_gsts[d] & m_gen[d]);
        n_cmp += 2;
        if (got !== exp) begin
          n_bad++;
          $display("FAIL %s dut%0d g=%0d p=%0d addr %h: rdata got %h expected %h",
                   cur_req, d, cfg_global, cfg_port, cfg_addr, got, exp);
        end
        if (gi !== ei) begin
          n_bad++;
          $display("FAIL R8 (%s) dut%0d: irq_out got %0b expected %0b", cur_req, d, gi, ei);
        end
      end
    end
  end

  // traffic driver
  always @(posedge clk) begin
    #1;
    case (traf_mode)
      1: begin xfer_valid = NP'($urandom); xfer_bytes = (NP*BW)'($urandom); end
      2: begin xfer_valid = '1; xfer_bytes = {NP{8'h40}}; end
      default: begin xfer_valid = '0; xfer_bytes = '0; end
    endcase
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit g, int p, logic [11:0] a, logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_global = g; cfg_port = 1'(p); cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_global = idle_g; cfg_port = idle_p; cfg_addr = idle_a; cfg_wdata = '0;
  endtask

  task automatic look(bit g, int p, logic [11:0] a);
    @(posedge clk); #1;
    cfg_global = g; cfg_port = 1'(p); cfg_addr = a;
    @(negedge clk);
  endtask

  task automatic watch(bit g, int p, logic [11:0] a);
    idle_g = g; idle_p = 1'(p); idle_a = a;
    @(posedge clk); #1;
    cfg_global = g; cfg_port = 1'(p); cfg_addr = a;
  endtask

  // byte total recovered from count plus status corrections (R4, R5)
  task automatic check_total(int p, string req);
    logic [31:0] c [2];
    logic [31:0] s [2];
    logic [31:0] l [2];
    look(0, p, 12'h288); c[0] = rdata_w; c[1] = rdata_o;
    look(0, p, 12'h100); s[0] = rdata_w; s[1] = rdata_o;
    look(0, p, 12'h290); l[0] = rdata_w; l[1] = rdata_o;
    for (int d = 0; d < 2; d++) begin
      longint rec;
      rec = longint'(c[d]);
      if (d == 0 && s[d][0]) rec += longint'(l[d]);
      if (d == 1 && s[d][1]) rec += span(1);
      n_cmp++;
      if (rec != tot[d][p]) begin
        n_bad++;
        $display("FAIL %s dut%0d port%0d: recovered total got %0d expected %0d", req, d, p, rec, tot[d][p]);
      end
    end
    watch(idle_g, int'(idle_p), idle_a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cmp_on = 1'b1;
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(4);
    look(0, 0, 12'h288); look(0, 0, 12'h100); look(0, 0, 12'h290); look(0, 1, 12'h290);
    look(0, 1, 12'h280); look(0, 1, 12'h10C); look(1, 0, 12'h100); look(1, 0, 12'h10C);

    cur_req = "R9";
    wr(0, 0, 12'h290, 32'h0001_1234);
    look(0, 0, 12'h290); look(0, 0, 12'h284); look(0, 0, 12'h108); look(0, 0, 12'h2A0);
    look(1, 0, 12'h108);

    cur_req = "R2";
    watch(0, 0, 12'h288);
    wr(0, 0, 12'h290, 32'h7FFF_FFFF);
    wr(0, 1, 12'h290, 32'h7FFF_FFFF);
    wr(0, 0, 12'h280, 32'h1);
    wr(0, 1, 12'h280, 32'h1);
    traf_mode = 1; idle(30);
    wr(0, 0, 12'h280, 32'h0);
    idle(20);
    watch(0, 1, 12'h288); idle(10);

    cur_req = "R3";
    watch(0, 0, 12'h288);
    wr(0, 0, 12'h280, 32'h1);
    traf_mode = 2; idle(5);
    wr(0, 0, 12'h284, 32'h1);
    idle(3);
    wr(0, 0, 12'h284, 32'h0);
    idle(3);

    cur_req = "R4";
    traf_mode = 0; idle(2);
    wr(0, 0, 12'h290, 32'd3000);
    wr(0, 1, 12'h290, 32'h0001_8000);
    wr(0, 0, 12'h284, 32'h1);
    wr(0, 1, 12'h284, 32'h1);
    traf_mode = 1;
    while (tot[0][0] < 4000) @(negedge clk);
    traf_mode = 0; idle(3);
    check_total(0, "R4");
    check_total(1, "R4");

    cur_req = "R6";
    watch(0, 0, 12'h100);
    wr(0, 0, 12'h108, 32'h2);
    idle(2);
    wr(0, 0, 12'h108, 32'h1);
    idle(2);
    wr(0, 0, 12'h290, 32'd10);
    traf_mode = 2; idle(4);
    wr(0, 0, 12'h108, 32'h3);
    idle(2);
    traf_mode = 0; idle(2);
    wr(0, 0, 12'h108, 32'h3);
    idle(2);

    cur_req = "R5";
    watch(0, 0, 12'h288);
    wr(0, 0, 12'h290, 32'h0001_8000);
    wr(0, 1, 12'h290, 32'h0001_8000);
    wr(0, 0, 12'h108, 32'h3);
    wr(0, 1, 12'h108, 32'h3);
    wr(0, 0, 12'h284, 32'h1);
    wr(0, 1, 12'h284, 32'h1);
    traf_mode = 1;
    while (tot[1][0] < 70000) @(negedge clk);
    traf_mode = 0; idle(3);
    check_total(0, "R5");
    check_total(1, "R5");

    cur_req = "R7";
    watch(1, 0, 12'h100);
    wr(0, 0, 12'h290, 32'd100);
    traf_mode = 1; idle(10);
    traf_mode = 0; idle(2);
    wr(0, 0, 12'h10C, 32'h1);
    idle(3);
    cur_req = "R8";
    wr(1, 0, 12'h10C, 32'h1);
    idle(3);
    wr(1, 0, 12'h108, 32'h1);
    idle(3);
    wr(0, 0, 12'h108, 32'h3);
    idle(2);
    wr(1, 0, 12'h108, 32'h1);
    idle(3);
    look(1, 0, 12'h10C);
    idle(2);

    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule